// File: doc/BRIEF.md
# Display RAM Address Generator

This block produces the word column (X) and row (Y) address for a bit-mapped display memory of 80 dot columns by 18 rows. It also produces the per-column write enables and the write data that place one display word on its dot columns. Software loads X and Y directly. After that, every display-data access, read or write, advances one of the two counters. A direction input picks which counter moves. When the moving counter passes its limit it returns to 0 and carries one step into the other counter.

Both limits are chosen at run time:
- **X limit** follows the word length. An 8-bit word gives 10 columns of words (0 to 9). A 6-bit word gives 14 (0 to 13), and the last of those holds only two dots.
- **Y limit** follows a two-bit duty code added to a row base fixed by a parameter.

Each word is placed with its most significant bit at its lowest dot column. A read returns the selected slice of a row supplied by the storage array. The storage array and the LCD drive waveforms are not part of this block.

Top module: `dadr_addr_gen`

## Requirements
- R1: While `rst_n` is low, `x_addr` and `y_addr` are 0, and they remain 0 at the first clock after release when no load or access occurs.
- R2: X limit is 9 when `word6`=0 and 13 when `word6`=1; an X step from the limit gives X=0.
- R3: With `x_first`=1 each access (`acc_stb`=1, `acc_wr` either value) adds 1 to X; with `x_first`=0 it adds 1 to Y. The new address appears on the clock edge that samples the access.
- R4: An X wrap in X-first mode adds 1 to Y (Y wrapping to 0 past its limit); a Y wrap in Y-first mode adds 1 to X (X wrapping to 0 past its limit).
- R5: Y limit is ROW_BASE-1 plus the duty code, where `duty_sel` 0,1,2,3 add 0,1,2,2 (default ROW_BASE 16: limits 15, 16, 17, 17); a Y step from the limit gives Y=0.
- R6: `x_ld` / `y_ld` set the counter to `x_ld_val` / `y_ld_val` on the next edge, winning over any step or carry on the same edge.
- R7: During a write access (`acc_stb`=1, `acc_wr`=1), `col_we` is set exactly on columns B..B+L-1 (L=8 or 6 by `word6`, B=X·L), and column B+k receives `wr_data` bit L-1-k; `col_we` is all zero otherwise.
- R8: No column at or above 80 is addressed: in 6-bit mode at X=13 only columns 78 and 79 are enabled, taking `wr_data` bits 5 and 4.
- R9: In 6-bit mode `wr_data` bits 7 and 6 reach no column and `rd_data` bits 7 and 6 read 0; in either mode `rd_data` bit L-1-k equals `row_rd` column B+k (0 for columns at or above 80).
- R10: Without an access or load, both addresses hold their value and `col_we` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word6 | input | 1 | Word length: 1 = 6-bit words, 0 = 8-bit words |
| duty_sel | input | 2 | Duty code selecting the Y limit |
| x_first | input | 1 | 1 = X advances per access, 0 = Y advances |
| acc_stb | input | 1 | One display-data access this cycle |
| acc_wr | input | 1 | 1 = the access is a write, 0 = a read |
| wr_data | input | 8 | Display word being written |
| x_ld | input | 1 | Load X address |
| x_ld_val | input | 4 | X value to load |
| y_ld | input | 1 | Load Y address |
| y_ld_val | input | 5 | Y value to load |
| row_rd | input | 80 | Row at the current Y as read from the storage array |
| x_addr | output | 4 | Current word column |
| y_addr | output | 5 | Current row |
| col_we | output | 80 | Per-column write enables |
| col_wdata | output | 80 | Write data placed on dot columns |
| rd_data | output | 8 | Word read from `row_rd` at the current X |

## Verification
The bench builds the block with its default parameters: 80 columns, 18 rows, row base 16, and word widths of 8 and 6. At these sizes a full walk over every word cell in every mode takes a few hundred accesses. It therefore sweeps both word lengths, all four duty codes including the aliased code 3, and both directions. Each sweep runs one whole traversal plus a few steps, so every wrap and carry is reached, and so is the two-dot tail word at X=13. Load-versus-step and load-versus-carry collisions, plus a reset in the middle of a run, are driven explicitly.

// File: rtl/dadr_pkg.sv
`timescale 1ns/1ps
package dadr_pkg;

   // highest word index for a given panel width and word length
   function automatic int unsigned word_limit(input int unsigned cols, input int unsigned wlen);
      return (cols + wlen - 1) / wlen - 1;
   endfunction

   // duty code 3 aliases code 2
   function automatic logic [1:0] duty_offset(input logic [1:0] code);
      return (code == 2'd3) ? 2'd2 : code;
   endfunction

endpackage

// File: rtl/dadr_axis_ctr.sv
`timescale 1ns/1ps
module dadr_axis_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] lim,
   output logic [W-1:0] q,
   output logic         at_lim
);

   // out-of-range values also fold to 0 on the next step
   assign at_lim = (q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load)   q <= load_val;
      else if (inc)    q <= at_lim ? '0 : q + W'(1);
   end

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && !at_lim) |=> q == $past(q) + W'(1));

   // covers the X limit (R2) and the Y limit (R5)
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && at_lim) |=> q == '0);

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(load_val));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load) |=> $stable(q));

endmodule

// File: rtl/dadr_col_map.sv
`timescale 1ns/1ps
module dadr_col_map #(
   parameter int NUM_COLS = 80,
   parameter int WIDE_W   = 8,
   parameter int BW       = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic [BW-1:0]       base,
   input  logic [BW-1:0]       wlen,
   input  logic [WIDE_W-1:0]   data,
   output logic [NUM_COLS-1:0] we,
   output logic [NUM_COLS-1:0] wdata
);

   localparam int IW = $clog2(WIDE_W);

   // one window compare per dot column; columns past the panel do not exist
   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      localparam logic [BW-1:0] CI = BW'(c);
      logic [BW-1:0] off;
      logic [IW-1:0] idx;
      logic          in_win;

      always_comb begin
         off    = CI - base;
         in_win = (CI >= base) && (off < wlen);
         idx    = IW'(wlen - BW'(1) - off);
      end

      assign we[c]    = wr_stb & in_win;
      assign wdata[c] = in_win & data[idx];
   end

   assert_we_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |-> we == '0);

   assert_we_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(we) <= WIDE_W);

endmodule

// File: rtl/dadr_rd_sel.sv
`timescale 1ns/1ps
module dadr_rd_sel #(
   parameter int NUM_COLS = 80,
   parameter int WIDE_W   = 8,
   parameter int NARROW_W = 6,
   parameter int BW       = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word6,
   input  logic [BW-1:0]       base,
   input  logic [NUM_COLS-1:0] row,
   output logic [WIDE_W-1:0]   rd
);

   localparam int CIW = $clog2(NUM_COLS);

   for (genvar j = 0; j < WIDE_W; j++) begin : g_bit
      logic [BW-1:0] col;
      logic          live;

      if (j < NARROW_W) begin : g_both
         always_comb begin
            col  = base + (word6 ? BW'(NARROW_W - 1 - j) : BW'(WIDE_W - 1 - j));
            live = 1'b1;
         end
      end else begin : g_wide_only
         always_comb begin
            col  = base + BW'(WIDE_W - 1 - j);
            live = !word6;
         end
      end

      assign rd[j] = live && (col < BW'(NUM_COLS)) && row[col[CIW-1:0]];
   end

   assert_narrow_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
      word6 |-> rd[WIDE_W-1:NARROW_W] == '0);

endmodule

// File: rtl/dadr_addr_gen.sv
`timescale 1ns/1ps
module dadr_addr_gen #(
   parameter int NUM_COLS = 80,
   parameter int NUM_ROWS = 18,
   parameter int ROW_BASE = 16,
   parameter int WIDE_W   = 8,
   parameter int NARROW_W = 6,
   localparam int XLIM8   = int'(dadr_pkg::word_limit(NUM_COLS, WIDE_W)),
   localparam int XLIM6   = int'(dadr_pkg::word_limit(NUM_COLS, NARROW_W)),
   localparam int XW      = $clog2(XLIM6 + 1),
   localparam int YW      = $clog2(NUM_ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                word6,
   input  logic [1:0]          duty_sel,
   input  logic                x_first,
   input  logic                acc_stb,
   input  logic                acc_wr,
   input  logic [WIDE_W-1:0]   wr_data,
   input  logic                x_ld,
   input  logic [XW-1:0]       x_ld_val,
   input  logic                y_ld,
   input  logic [YW-1:0]       y_ld_val,
   input  logic [NUM_COLS-1:0] row_rd,
   output logic [XW-1:0]       x_addr,
   output logic [YW-1:0]       y_addr,
   output logic [NUM_COLS-1:0] col_we,
   output logic [NUM_COLS-1:0] col_wdata,
   output logic [WIDE_W-1:0]   rd_data
);

   localparam int BW = $clog2(NUM_COLS + WIDE_W) + 1;

   if (NARROW_W >= WIDE_W)        begin : g_bad_w  $error("narrow word must be shorter"); end
   if (ROW_BASE + 2 > NUM_ROWS)   begin : g_bad_r  $error("duty range exceeds rows");     end
   if (ROW_BASE < 1)              begin : g_bad_b  $error("row base must be positive");   end

   logic [XW-1:0] x_lim;
   logic [YW-1:0] y_lim;
   logic          x_at_lim, y_at_lim;
   logic          x_inc, y_inc;
   logic [BW-1:0] base, wlen;

   always_comb begin
      x_lim = word6 ? XW'(XLIM6) : XW'(XLIM8);
      y_lim = YW'(ROW_BASE - 1) + YW'(dadr_pkg::duty_offset(duty_sel));
   end

   // carries come from the at-limit flags, never from the other counter's step
   assign x_inc = acc_stb & ( x_first | y_at_lim);
   assign y_inc = acc_stb & (~x_first | x_at_lim);

   dadr_axis_ctr #(.W(XW)) u_x (
      .clk(clk), .rst_n(rst_n), .inc(x_inc), .load(x_ld), .load_val(x_ld_val),
      .lim(x_lim), .q(x_addr), .at_lim(x_at_lim)
   );

   dadr_axis_ctr #(.W(YW)) u_y (
      .clk(clk), .rst_n(rst_n), .inc(y_inc), .load(y_ld), .load_val(y_ld_val),
      .lim(y_lim), .q(y_addr), .at_lim(y_at_lim)
   );

   always_comb begin
      wlen = word6 ? BW'(NARROW_W) : BW'(WIDE_W);
      base = word6 ? BW'(x_addr) * BW'(NARROW_W) : BW'(x_addr) * BW'(WIDE_W);
   end

   dadr_col_map #(.NUM_COLS(NUM_COLS), .WIDE_W(WIDE_W), .BW(BW)) u_map (
      .clk(clk), .rst_n(rst_n), .wr_stb(acc_stb & acc_wr), .base(base), .wlen(wlen),
      .data(wr_data), .we(col_we), .wdata(col_wdata)
   );

   dadr_rd_sel #(.NUM_COLS(NUM_COLS), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .BW(BW)) u_rd (
      .clk(clk), .rst_n(rst_n), .word6(word6), .base(base), .row(row_rd), .rd(rd_data)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_R1: assert (x_addr == '0 && y_addr == '0);
      end
   end

   assert_xcarry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && x_first && x_at_lim && !y_ld) |=> y_addr != $past(y_addr));

   assert_ycarry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && !x_first && y_at_lim && !x_ld) |=> x_addr != $past(x_addr));

endmodule

// File: tb/tb_dadr_addr_gen.sv
`timescale 1ns/1ps
module tb_dadr_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word6 = 1'b0;
   logic [1:0]  duty_sel = 2'd0;
   logic        x_first = 1'b0;
   logic        acc_stb = 1'b0;
   logic        acc_wr = 1'b0;
   logic [7:0]  wr_data = 8'd0;
   logic        x_ld = 1'b0;
   logic [3:0]  x_ld_val = 4'd0;
   logic        y_ld = 1'b0;
   logic [4:0]  y_ld_val = 5'd0;
   logic [79:0] row_rd = 80'hA5F0_3C96_0F5A_C3E1_7B24;
   logic [3:0]  x_addr;
   logic [4:0]  y_addr;
   logic [79:0] col_we, col_wdata;
   logic [7:0]  rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int ex = 0;
   int ey = 0;

   always #2.5 clk = ~clk;

   dadr_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .word6(word6), .duty_sel(duty_sel), .x_first(x_first),
      .acc_stb(acc_stb), .acc_wr(acc_wr), .wr_data(wr_data), .x_ld(x_ld), .x_ld_val(x_ld_val),
      .y_ld(y_ld), .y_ld_val(y_ld_val), .row_rd(row_rd), .x_addr(x_addr), .y_addr(y_addr),
      .col_we(col_we), .col_wdata(col_wdata), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int xmax(input bit w6);
      return w6 ? 13 : 9;
   endfunction

   function automatic int ymax(input logic [1:0] d);
      return 15 + ((d == 2'd3) ? 2 : int'(d));
   endfunction

   // one clock of stimulus, entered and left at a falling edge
   task automatic step(input bit acc, input bit wr, input logic [7:0] d,
                       input bit xl, input int xv, input bit yl, input int yv, input string tag_in);
      logic [79:0] ewe, ewd;
      logic [7:0]  erd;
      int wl, b;
      string tag;
      acc_stb = acc; acc_wr = wr; wr_data = d;
      x_ld = xl; x_ld_val = 4'(xv); y_ld = yl; y_ld_val = 5'(yv);
      #1;
      wl = word6 ? 6 : 8;
      b = ex * wl;
      ewe = '0; ewd = '0; erd = '0;
      for (int k = 0; k < wl; k++) begin
         if (b + k < 80) begin
            ewe[b+k] = 1'b1;
            ewd[b+k] = d[wl-1-k];
            erd[wl-1-k] = row_rd[b+k];
         end
      end
      if (acc && wr) begin
         if (word6 && ex == 13) begin
            chk("R8 tail enables", col_we, ewe);
            chk("R8 tail data", col_wdata, ewd);
         end else begin
            chk("R7 enables", col_we, ewe);
            chk(word6 ? "R9 narrow write data" : "R7 write data", col_wdata, ewd);
         end
      end else begin
         chk("R10 no enables without write", col_we, '0);
      end
      chk(word6 ? "R9 narrow read" : "R9 wide read", {72'd0, rd_data}, {72'd0, erd});
      tag = tag_in;
      if (tag == "") begin
         if (x_first) tag = (ex >= xmax(word6)) ? "R2 X wrap R4 carry" : "R3 X step";
         else         tag = (ey >= ymax(duty_sel)) ? "R5 Y wrap R4 carry" : "R3 Y step";
      end
      @(posedge clk);
      if (acc) begin
         if (x_first) begin
            if (ex >= xmax(word6)) begin
               ex = 0;
               ey = (ey >= ymax(duty_sel)) ? 0 : ey + 1;
            end else ex++;
         end else begin
            if (ey >= ymax(duty_sel)) begin
               ey = 0;
               ex = (ex >= xmax(word6)) ? 0 : ex + 1;
            end else ey++;
         end
      end
      if (xl) ex = xv;
      if (yl) ey = yv;
      @(negedge clk);
      acc_stb = 1'b0; acc_wr = 1'b0; x_ld = 1'b0; y_ld = 1'b0;
      chk({tag, " X"}, 80'(x_addr), 80'(ex));
      chk({tag, " Y"}, 80'(y_addr), 80'(ey));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset X", 80'(x_addr), 80'd0);
      chk("R1 reset Y", 80'(y_addr), 80'd0);
      rst_n = 1'b1;
      step(0, 0, 8'h00, 0, 0, 0, 0, "R1 after release");
      step(0, 0, 8'h00, 1, 5, 1, 3, "R6 load");
      rst_n = 1'b0; ex = 0; ey = 0;
      @(negedge clk);
      chk("R1 mid-run reset X", 80'(x_addr), 80'd0);
      chk("R1 mid-run reset Y", 80'(y_addr), 80'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int w = 0; w < 2; w++) begin
         for (int dc = 0; dc < 4; dc++) begin
            for (int dir = 0; dir < 2; dir++) begin
               int n;
               word6 = w[0]; duty_sel = 2'(dc); x_first = dir[0];
               step(0, 0, 8'h00, 1, 0, 1, 0, "R6 load origin");
               n = (xmax(word6) + 1) * (ymax(duty_sel) + 1) + 3;
               for (int i = 0; i < n; i++) begin
                  step(1, (i % 2) == 0, 8'(i * 37 + 13), 0, 0, 0, 0, "");
                  row_rd = {row_rd[78:0], row_rd[79] ^ row_rd[37]};
               end
               step(0, 0, 8'hFF, 0, 0, 0, 0, "R10 idle hold");
            end
         end
      end

      // load against step and against carry
      word6 = 1'b0; duty_sel = 2'd2; x_first = 1'b1;
      step(0, 0, 8'h00, 1, 3, 1, 2, "R6 load");
      step(1, 1, 8'h5A, 1, 7, 0, 0, "R6 load beats step");
      x_first = 1'b0;
      step(0, 0, 8'h00, 1, 4, 1, 17, "R6 load");
      step(1, 0, 8'h00, 1, 6, 0, 0, "R6 load beats carry");

      // narrow mode: top two data bits reach nothing, tail word
      word6 = 1'b1;
      step(0, 0, 8'h00, 1, 0, 0, 0, "R6 load");
      step(1, 1, 8'hC0, 0, 0, 0, 0, "R9 upper bits ignored");
      step(0, 0, 8'h00, 1, 13, 0, 0, "R6 load tail");
      step(1, 1, 8'hFF, 0, 0, 0, 0, "R8 tail write");
      step(1, 0, 8'hFF, 0, 0, 0, 0, "R3 read advances");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule